// File: doc/BRIEF.md
# DMA Descriptor Chaining Controller

This block keeps the current and next descriptor pointers of one DMA channel. Each 64-bit pointer is held as two 32-bit halves, and software reaches the halves through a small register bus. The block decides whether a software write to a next-pointer half should start a chaining operation. A chaining operation moves the whole next pointer into the current pointer, empties the next pointer, raises a sticky chain flag and sends a one-clock start pulse to the descriptor fetch engine.

Chaining can only start while the channel is stopped and free of error. Two disable inputs, one for each half, choose which writes are allowed to start a chain. Software can set both disables to load a full 64-bit next pointer safely while the channel is running. Descriptor fetching, data movement and error detection are outside this block. The run flag, the error flag and the start pulse are their only connection to it.

Top module: `dmac_chain_ctrl`

## Requirements
- R1: After reset, both pointers, the chain flag, the start pulse and the read data at every offset are zero.
- R2: While `run_i` is high, a write to a next-pointer half updates only that half; no start pulse follows and the current pointer does not change.
- R3: While `run_i` is low and `err_i` is high, a write to a next-pointer half updates only that half and never starts a chain.
- R4: A chaining operation loads the current pointer with the 64-bit next pointer as it stands including the triggering write, sets both next halves to zero and sets the chain flag, all at the clock edge that accepts the write.
- R5: `start_o` is high for exactly the one cycle after the edge that accepts each triggering write. It is low in every other cycle, and back-to-back triggering writes give back-to-back pulses.
- R6: With both disables low, a write to either next half starts a chain when the resulting 64-bit next pointer is non-zero. When the result is zero, nothing happens.
- R7: With only `dis_lo_i` high, writes to the low half never start a chain. A write to the high half starts one only if the written value is non-zero.
- R8: With only `dis_hi_i` high, writes to the high half never start a chain. A write to the low half starts one only if the written value is non-zero.
- R9: With both disables high, no write starts a chain.
- R10: The register offsets are: 0 current low, 1 current high, 2 next low, 3 next high, and 4 status, with the chain flag at bit 0. All other offsets read as zero. Writes to offsets 0 and 1 have no effect.
- R11: Writing 1 to status bit 0 clears the chain flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe; each strobed cycle is one accepted write |
| reg_addr | input | ADDR_W (3) | Register offset for both reads and writes |
| reg_wdata | input | HALF_W (32) | Write data |
| reg_rdata | output | HALF_W (32) | Combinational read data for `reg_addr` |
| run_i | input | 1 | Channel run flag |
| err_i | input | 1 | Channel error flag |
| dis_lo_i | input | 1 | Stops writes to the low next half from starting a chain |
| dis_hi_i | input | 1 | Stops writes to the high next half from starting a chain |
| cur_ptr_o | output | 2*HALF_W (64) | Current descriptor pointer |
| chain_o | output | 1 | Sticky chain flag |
| start_o | output | 1 | One-cycle start request to the descriptor fetch engine |

## Verification
The inline properties are checked on every cycle. They cover four points:
- no start pulse follows a write made while the channel runs, while the error flag is set, or while both halves are disabled;
- each pulse comes directly after an accepted write;
- during a pulse the next pointer is empty and the chain flag is set;
- the current pointer changes only at the edge that raises a pulse.

Some behaviour can only be shown by the bench's scenarios, where a cycle-by-cycle model is compared on every clock:
- the exact pointer value that gets loaded;
- the way each disable combination judges zero and non-zero halves;
- the clear-on-one status flag;
- the ignored writes to the current-pointer offsets.

// File: rtl/dmac_chain_pkg.sv
package dmac_chain_pkg;
   // register offsets on the software bus
   localparam int unsigned OFS_CUR_LO = 0;
   localparam int unsigned OFS_CUR_HI = 1;
   localparam int unsigned OFS_NXT_LO = 2;
   localparam int unsigned OFS_NXT_HI = 3;
   localparam int unsigned OFS_STAT   = 4;
   localparam int unsigned STAT_CHAIN_BIT = 0;

   // index of each pointer half inside the packed half arrays
   localparam int unsigned HALF_LO = 0;
   localparam int unsigned HALF_HI = 1;
   localparam int unsigned N_HALVES = 2;

   typedef enum logic [1:0] {
      JUDGE_EITHER = 2'b00,
      JUDGE_HI     = 2'b01,
      JUDGE_LO     = 2'b10,
      JUDGE_NONE   = 2'b11
   } judge_e;
endpackage

// File: rtl/dmac_ptr_half.sv
module dmac_ptr_half #(
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_nxt,
   input  logic [HALF_W-1:0] wdata,
   input  logic              chain_go,
   output logic [HALF_W-1:0] nxt_after,
   output logic [HALF_W-1:0] nxt_q,
   output logic [HALF_W-1:0] cur_q
);
   // value the next half holds once this cycle's write lands
   assign nxt_after = wr_nxt ? wdata : nxt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_q <= '0;
         cur_q <= '0;
      end else if (chain_go) begin
         cur_q <= nxt_after;
         nxt_q <= '0;
      end else if (wr_nxt) begin
         nxt_q <= wdata;
      end
   end
endmodule

// File: rtl/dmac_chain_decide.sv
module dmac_chain_decide
   import dmac_chain_pkg::*;
#(
   parameter int unsigned HALF_W = 32
) (
   input  logic              run_i,
   input  logic              err_i,
   input  logic              dis_lo_i,
   input  logic              dis_hi_i,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] lo_after,
   input  logic [HALF_W-1:0] hi_after,
   output logic              chain_go
);
   logic   idle;
   logic   lo_nz, hi_nz;
   judge_e mode;

   assign idle  = !run_i && !err_i;
   assign lo_nz = |lo_after;
   assign hi_nz = |hi_after;
   assign mode  = judge_e'({dis_hi_i, dis_lo_i});

   always_comb begin
      chain_go = 1'b0;
      if (idle) begin
         unique case (mode)
            JUDGE_EITHER: chain_go = (wr_lo || wr_hi) && (lo_nz || hi_nz);
            JUDGE_HI:     chain_go = wr_hi && hi_nz;
            JUDGE_LO:     chain_go = wr_lo && lo_nz;
            JUDGE_NONE:   chain_go = 1'b0;
            default:      chain_go = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/dmac_reg_rd.sv
module dmac_reg_rd
   import dmac_chain_pkg::*;
#(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [HALF_W-1:0] cur_lo,
   input  logic [HALF_W-1:0] cur_hi,
   input  logic [HALF_W-1:0] nxt_lo,
   input  logic [HALF_W-1:0] nxt_hi,
   input  logic              chain,
   output logic [HALF_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CUR_LO))      rdata = cur_lo;
      else if (addr == ADDR_W'(OFS_CUR_HI)) rdata = cur_hi;
      else if (addr == ADDR_W'(OFS_NXT_LO)) rdata = nxt_lo;
      else if (addr == ADDR_W'(OFS_NXT_HI)) rdata = nxt_hi;
      else if (addr == ADDR_W'(OFS_STAT))   rdata[STAT_CHAIN_BIT] = chain;
   end
endmodule

// File: rtl/dmac_chain_ctrl.sv
module dmac_chain_ctrl
   import dmac_chain_pkg::*;
#(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [HALF_W-1:0]     reg_wdata,
   output logic [HALF_W-1:0]     reg_rdata,
   input  logic                  run_i,
   input  logic                  err_i,
   input  logic                  dis_lo_i,
   input  logic                  dis_hi_i,
   output logic [2*HALF_W-1:0]   cur_ptr_o,
   output logic                  chain_o,
   output logic                  start_o
);
   localparam int unsigned PTR_W = N_HALVES * HALF_W;

   generate
      if (HALF_W < 8 || HALF_W > 64) begin : g_bad_width
         $error("dmac_chain_ctrl: HALF_W must be within 8..64");
      end
      if ((1 << ADDR_W) <= OFS_STAT) begin : g_bad_addr
         $error("dmac_chain_ctrl: ADDR_W too narrow for the status offset");
      end
   endgenerate

   logic [N_HALVES-1:0]             wr_half;
   logic [N_HALVES-1:0][HALF_W-1:0] nxt_after, nxt_q, cur_q;
   logic                            chain_go;
   logic                            stat_clr;
   logic                            chain_q, start_q;

   assign wr_half[HALF_LO] = reg_wr && (reg_addr == ADDR_W'(OFS_NXT_LO));
   assign wr_half[HALF_HI] = reg_wr && (reg_addr == ADDR_W'(OFS_NXT_HI));

   genvar gi;
   generate
      for (gi = 0; gi < N_HALVES; gi++) begin : g_half
         dmac_ptr_half #(.HALF_W(HALF_W)) half_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_nxt    (wr_half[gi]),
            .wdata     (reg_wdata),
            .chain_go  (chain_go),
            .nxt_after (nxt_after[gi]),
            .nxt_q     (nxt_q[gi]),
            .cur_q     (cur_q[gi])
         );
      end
   endgenerate

   dmac_chain_decide #(.HALF_W(HALF_W)) decide_i (
      .run_i    (run_i),
      .err_i    (err_i),
      .dis_lo_i (dis_lo_i),
      .dis_hi_i (dis_hi_i),
      .wr_lo    (wr_half[HALF_LO]),
      .wr_hi    (wr_half[HALF_HI]),
      .lo_after (nxt_after[HALF_LO]),
      .hi_after (nxt_after[HALF_HI]),
      .chain_go (chain_go)
   );

   assign stat_clr = reg_wr && (reg_addr == ADDR_W'(OFS_STAT))
                     && reg_wdata[STAT_CHAIN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= chain_go;
         if (chain_go)      chain_q <= 1'b1;
         else if (stat_clr) chain_q <= 1'b0;
      end
   end

   dmac_reg_rd #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) rd_i (
      .addr   (reg_addr),
      .cur_lo (cur_q[HALF_LO]),
      .cur_hi (cur_q[HALF_HI]),
      .nxt_lo (nxt_q[HALF_LO]),
      .nxt_hi (nxt_q[HALF_HI]),
      .chain  (chain_q),
      .rdata  (reg_rdata)
   );

   assign cur_ptr_o = PTR_W'(cur_q);
   assign chain_o   = chain_q;
   assign start_o   = start_q;

   // R2: a write while running is never followed by a start
   a_r2_run_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && run_i) |=> !start_o);
   // R3: a write while the error flag is up is never followed by a start
   a_r3_err_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && err_i) |=> !start_o);
   // R9: both halves disabled means no start
   a_r9_all_disabled : assert property (@(posedge clk) disable iff (!rst_n)
      (dis_lo_i && dis_hi_i) |=> !start_o);
   // R4: during the pulse the next pointer is empty and the flag is set
   a_r4_next_emptied : assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (nxt_q == '0 && chain_o));
   // R4: the current pointer moves only at a chaining edge
   a_r4_cur_held : assert property (@(posedge clk) disable iff (!rst_n)
      !start_o |-> $stable(cur_ptr_o));
   // R5: every pulse comes from a write accepted one edge before
   a_r5_pulse_after_write : assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(reg_wr));
endmodule

// File: tb/dmac_chain_ctrl_tb.sv
module dmac_chain_ctrl_tb_top;
   localparam int HW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          b_wr = 1'b0;
   logic [AW-1:0] b_addr = '0;
   logic [HW-1:0] b_wdata = '0;
   logic          b_run = 1'b0, b_err = 1'b0, b_dlo = 1'b0, b_dhi = 1'b0;
   logic [HW-1:0] rdata;
   logic [63:0]   cur_ptr;
   logic          chain, start;

   always #5 clk = ~clk;

   dmac_chain_ctrl #(.HALF_W(HW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_addr(b_addr),
      .reg_wdata(b_wdata), .reg_rdata(rdata), .run_i(b_run), .err_i(b_err),
      .dis_lo_i(b_dlo), .dis_hi_i(b_dhi), .cur_ptr_o(cur_ptr),
      .chain_o(chain), .start_o(start)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   logic [31:0] m_cl = 0, m_ch = 0, m_nl = 0, m_nh = 0;
   bit          m_chain = 0, m_start = 0;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [AW-1:0] a);
      case (a)
         3'd0: return m_cl;
         3'd1: return m_ch;
         3'd2: return m_nl;
         3'd3: return m_nh;
         3'd4: return {31'd0, m_chain};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_step();
      logic [31:0] nl, nh;
      bit wl, wh, go;
      nl = m_nl; nh = m_nh;
      wl = b_wr && b_addr == 3'd2;
      wh = b_wr && b_addr == 3'd3;
      if (wl) nl = b_wdata;
      if (wh) nh = b_wdata;
      go = 0;
      if (!b_run && !b_err) begin
         if (!b_dlo && !b_dhi)     go = (wl || wh) && (nl != 0 || nh != 0);
         else if (b_dlo && !b_dhi) go = wh && nh != 0;
         else if (!b_dlo && b_dhi) go = wl && nl != 0;
      end
      if (go) begin
         m_cl = nl; m_ch = nh; m_nl = 0; m_nh = 0; m_chain = 1;
      end else begin
         m_nl = nl; m_nh = nh;
         if (b_wr && b_addr == 3'd4 && b_wdata[0]) m_chain = 0;
      end
      m_start = go;
   endtask

   task automatic compare(input string tag);
      chk(tag, "cur_ptr", cur_ptr, {m_ch, m_cl});
      chk(tag, "start",   64'(start), 64'(m_start));
      chk(tag, "chain",   64'(chain), 64'(m_chain));
      chk(tag, "rdata",   64'(rdata), 64'(m_read(b_addr)));
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic cycle(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input string tag, input int a, input logic [31:0] d);
      b_wr = 1; b_addr = AW'(a); b_wdata = d;
      cycle(tag);
      b_wr = 0; b_wdata = 0;
   endtask

   task automatic rd(input string tag, input int a);
      b_addr = AW'(a);
      cycle(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state at every offset
      for (int a = 0; a < 8; a++) begin
         b_addr = AW'(a);
         #1 compare("R1");
      end
      cycle("R1");

      // R10: writes to current-pointer offsets ignored, unused offset reads zero
      b_run = 1;
      wr("R10", 0, 32'hDEAD_BEEF);
      wr("R10", 1, 32'h1234_5678);
      rd("R10", 0); rd("R10", 1); rd("R10", 6);

      // R2: running - writes only update
      wr("R2", 2, 32'h0000_1000);
      wr("R2", 3, 32'h0000_0002);
      rd("R2", 2); rd("R2", 3); rd("R2", 0);

      // R3: stopped with error - no chain
      b_run = 0; b_err = 1;
      wr("R3", 2, 32'h0000_2000);
      rd("R3", 2); rd("R3", 4);

      // R6/R4/R5: both enabled, high write triggers full 64-bit move
      b_err = 0;
      wr("R6", 3, 32'h0000_0005);
      rd("R5", 0); rd("R4", 1); rd("R4", 2); rd("R4", 3);

      // R11: writing 0 keeps the flag, writing 1 clears it
      wr("R11", 4, 32'h0000_0000);
      rd("R11", 4);
      wr("R11", 4, 32'h0000_0001);
      rd("R11", 4);

      // R6: zero write with empty next pointer does nothing
      wr("R6", 2, 32'h0);
      rd("R6", 0);

      // R7: only low disabled
      b_dlo = 1;
      wr("R7", 2, 32'h0000_3000);
      wr("R7", 3, 32'h0000_0000);
      rd("R7", 2);
      wr("R7", 3, 32'h0000_0007);
      rd("R7", 0); rd("R7", 1);

      // R8: only high disabled
      b_dlo = 0; b_dhi = 1;
      wr("R8", 3, 32'h0000_0009);
      rd("R8", 3);
      wr("R8", 2, 32'h0000_0040);
      rd("R8", 0); rd("R8", 1); rd("R8", 3);

      // R9: both disabled while stopped, writes only update
      b_dlo = 1;
      wr("R9", 2, 32'h0000_0011);
      wr("R9", 3, 32'h0000_0022);
      rd("R9", 2); rd("R9", 3); rd("R9", 0);

      // R5: back-to-back triggers give back-to-back pulses
      b_dlo = 0; b_dhi = 0;
      wr("R5", 2, 32'h0000_0050);
      wr("R5", 2, 32'h0000_0060);
      rd("R5", 0); rd("R5", 1);

      // R2: running with new pointer after chain does not move current
      b_run = 1;
      wr("R2", 3, 32'hAAAA_0000);
      rd("R2", 1); rd("R2", 3);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule